// File: doc/BRIEF.md
# Linear Image Sensor Timing Generator

This block drives a linear image sensor and its sampling converter from a single fast reference clock. A prescaler splits the reference into pixel slots of `DIV` reference cycles each. A frame sequencer counts slots and opens each frame with an active-low readout-gate pulse. While the gate is low the pixel clock is held high. After the gate, the pixel clock runs at 50% duty for the programmed number of pixel periods. Inside that readout, a window of `NPIX` slots carries one conversion-start pulse per slot. Each pulse sits on the high half of the pixel clock, so every effective pixel gets exactly one conversion.

A host writes the frame length, counted in pixel clock pulses after the gate, through a value bus and a one-cycle load strobe. The value is staged and only takes effect when the current frame ends, so a frame is never cut short or stretched midway. Values that are too short for a full readout are raised to the minimum. With a 20 MHz reference and `DIV`=20 the pixel clock is 1 MHz. `DIV` should be chosen so that the pixel clock stays at or below 2 MHz. All three outputs come straight from flops in the reference domain.

Top module: `lis_timing_gen`

## Requirements
- R1: Outside the gate, the pixel clock repeats every `DIV` reference cycles: high for the first `DIV`/2 cycles of each slot, low for the remaining `DIV`/2.
- R2: A frame is `GATE_LEN` + P slots, where P is the active period. The readout gate is low for exactly the first `GATE_LEN` slots (`GATE_LEN`×`DIV` reference cycles) and high for the rest.
- R3: The pixel clock stays high for the whole gate. It then gives exactly P high pulses (P falling edges) before the next gate.
- R4: Exactly `NPIX` conversion-start pulses occur per frame. They fall in slots `GATE_LEN+OFFSET` through `GATE_LEN+OFFSET+NPIX-1` (slots counted from 0 at the gate start). Each pulse is high during the first half of its slot only, while the pixel clock is high.
- R5: A value loaded with the strobe becomes the active period on the first frame that starts after the load. A load on the same edge as the frame's last reference cycle applies only to the frame after next.
- R6: A loaded value below `NPIX+NDUMMY+3` is replaced by `NPIX+NDUMMY+3`.
- R7: During reset, the gate is high, the pixel clock is low and conversion start is low, and the reset period is `RESET_PERIOD`. Each output is registered, so the value after reference edge k reflects sequencer state k-1. The first edge after reset release starts a frame with the gate low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_period | input | PW | Requested pixel clock pulses per frame after the gate |
| cfg_load | input | 1 | One-cycle strobe that stages `cfg_period` |
| pix_clk | output | 1 | Sensor pixel clock |
| rd_gate_n | output | 1 | Active-low readout gate |
| conv_start | output | 1 | Converter start pulse |

## Verification
Every output is due one reference edge after the sequencer state it encodes. The bench therefore tracks its own position count and compares the outputs sampled on the falling edge after each rising edge against the values for the position held before that edge. A period load is due at the frame boundary: the bench applies the staged value when its count reaches the frame's last reference cycle, the same edge on which the design swaps it in. Per-frame pulse totals are tallied over the samples of one frame and checked at that same boundary.

// File: rtl/lis_pkg.sv
// Shared types for the linear image sensor timing generator.
// Assumes nothing beyond the zone ordering within one frame.
package lis_pkg;
    // Slot classes within one frame, in time order.
    typedef enum logic [1:0] {
        ZONE_GATE = 2'd0,  // readout gate low, pixel clock parked high
        ZONE_LEAD = 2'd1,  // pixel clock runs, no conversions yet
        ZONE_PIX  = 2'd2,  // effective pixels, one conversion per slot
        ZONE_TAIL = 2'd3   // remaining pixel clocks up to frame end
    } lis_zone_e;
endpackage

// File: rtl/lis_clk_div.sv
// Prescaler: splits the reference clock into pixel slots of DIV cycles.
// Reports the first half of each slot and the slot's last cycle.
// Assumes DIV is even and at least 2.
module lis_clk_div #(
    parameter int DIV = 20
) (
    input  logic clk,
    input  logic rst_n,
    output logic first_half,
    output logic slot_end
);
    localparam int PHW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PHW-1:0] PH_LAST = PHW'(DIV - 1);
    localparam logic [PHW-1:0] PH_HALF = PHW'(DIV / 2);

    logic [PHW-1:0] ph;

    // Phase counter wraps after DIV reference cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph <= '0;
        else if (ph == PH_LAST)
            ph <= '0;
        else
            ph <= ph + 1'b1;
    end

    assign first_half = (ph < PH_HALF);
    assign slot_end   = (ph == PH_LAST);

    assert_first_half_follows_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        slot_end |=> first_half);
    assert_phase_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ph <= PH_LAST);
endmodule

// File: rtl/lis_frame_seq.sv
// Frame sequencer: counts pixel slots, classifies each slot into a zone,
// and swaps a staged, clamped frame period in at the frame boundary.
// Assumes OFFSET + NPIX <= NDUMMY + NPIX and RESET_PERIOD >= the minimum.
module lis_frame_seq
    import lis_pkg::*;
#(
    parameter int PW           = 16,
    parameter int GATE_LEN     = 8,
    parameter int NPIX         = 2048,
    parameter int NDUMMY       = 38,
    parameter int OFFSET       = 32,
    parameter int RESET_PERIOD = 2100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_end,
    input  logic [PW-1:0] cfg_period,
    input  logic          cfg_load,
    output lis_zone_e     zone
);
    localparam int SW = PW + 1;
    localparam logic [PW-1:0] MIN_P   = PW'(NPIX + NDUMMY + 3);
    localparam logic [PW-1:0] RST_P   = PW'(RESET_PERIOD);
    localparam logic [SW-1:0] GATE_S  = SW'(GATE_LEN);
    localparam logic [SW-1:0] PIX_LO  = SW'(GATE_LEN + OFFSET);
    localparam logic [SW-1:0] PIX_HI  = SW'(GATE_LEN + OFFSET + NPIX);

    logic [PW-1:0] pend_p;
    logic [PW-1:0] act_p;
    logic [SW-1:0] slot;
    logic [SW-1:0] last_slot;
    logic          wrap;

    assign last_slot = GATE_S + {1'b0, act_p} - 1'b1;
    assign wrap      = slot_end && (slot == last_slot);

    // Stage a host value, raised to the shortest legal frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_p <= RST_P;
        else if (cfg_load)
            pend_p <= (cfg_period < MIN_P) ? MIN_P : cfg_period;
    end

    // Slot counter and period swap at the frame boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot  <= '0;
            act_p <= RST_P;
        end else if (wrap) begin
            slot  <= '0;
            act_p <= pend_p;
        end else if (slot_end) begin
            slot  <= slot + 1'b1;
        end
    end

    // Zone decode of the current slot.
    always_comb begin
        if (slot < GATE_S)
            zone = ZONE_GATE;
        else if (slot < PIX_LO)
            zone = ZONE_LEAD;
        else if (slot < PIX_HI)
            zone = ZONE_PIX;
        else
            zone = ZONE_TAIL;
    end

    assert_period_held_midframe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(act_p));
    assert_active_period_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        act_p >= MIN_P);
    assert_staged_period_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pend_p >= MIN_P);
    assert_slot_within_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        slot <= last_slot);
endmodule

// File: rtl/lis_drive_out.sv
// Output stage: turns zone and slot half into registered sensor drives.
// Assumes zone and first_half describe the same reference cycle.
module lis_drive_out
    import lis_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lis_zone_e zone,
    input  logic      first_half,
    output logic      pix_clk,
    output logic      rd_gate_n,
    output logic      conv_start
);
    // Register every drive so no decoded glitch reaches a pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_clk    <= 1'b0;
            rd_gate_n  <= 1'b1;
            conv_start <= 1'b0;
        end else begin
            pix_clk    <= (zone == ZONE_GATE) || first_half;
            rd_gate_n  <= (zone != ZONE_GATE);
            conv_start <= (zone == ZONE_PIX) && first_half;
        end
    end

    assert_conv_inside_pixel_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> pix_clk);
    assert_conv_not_in_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> rd_gate_n);
    assert_pixel_parked_in_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_gate_n |-> pix_clk);
endmodule

// File: rtl/lis_timing_gen.sv
// Top of the linear image sensor timing generator: prescaler, frame
// sequencer and registered output stage, all on the reference clock.
// Assumes DIV even, OFFSET <= NDUMMY, RESET_PERIOD >= NPIX+NDUMMY+3.
module lis_timing_gen
    import lis_pkg::*;
#(
    parameter int DIV          = 20,
    parameter int PW           = 16,
    parameter int GATE_LEN     = 8,
    parameter int NPIX         = 2048,
    parameter int NDUMMY       = 38,
    parameter int OFFSET       = 32,
    parameter int RESET_PERIOD = 2100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] cfg_period,
    input  logic          cfg_load,
    output logic          pix_clk,
    output logic          rd_gate_n,
    output logic          conv_start
);
    logic      first_half;
    logic      slot_end;
    lis_zone_e zone;

    lis_clk_div #(.DIV(DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_half (first_half),
        .slot_end   (slot_end)
    );

    lis_frame_seq #(
        .PW           (PW),
        .GATE_LEN     (GATE_LEN),
        .NPIX         (NPIX),
        .NDUMMY       (NDUMMY),
        .OFFSET       (OFFSET),
        .RESET_PERIOD (RESET_PERIOD)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_end   (slot_end),
        .cfg_period (cfg_period),
        .cfg_load   (cfg_load),
        .zone       (zone)
    );

    lis_drive_out u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .zone       (zone),
        .first_half (first_half),
        .pix_clk    (pix_clk),
        .rd_gate_n  (rd_gate_n),
        .conv_start (conv_start)
    );
endmodule

// File: tb/lis_timing_gen_tb.sv
// Bench: small configuration, every reference cycle checked against a
// position count; per-frame pulse totals checked at each frame boundary.
module lis_timing_gen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DIV   = 4;
    localparam int PW    = 16;
    localparam int GATE  = 2;
    localparam int NPIX  = 8;
    localparam int NDUM  = 4;
    localparam int OFS   = 1;
    localparam int RSTP  = 16;
    localparam int MINP  = NPIX + NDUM + 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PW-1:0] cfg_period = '0;
    logic cfg_load = 1'b0;
    logic pix_clk, rd_gate_n, conv_start;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;
    bit done = 0;

    // model state
    int mq = 0, act = RSTP, pend = RSTP;
    int falls = 0, crises = 0;
    logic prev_pix = 1'b0, prev_conv = 1'b0;
    string tag = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    lis_timing_gen #(
        .DIV(DIV), .PW(PW), .GATE_LEN(GATE), .NPIX(NPIX),
        .NDUMMY(NDUM), .OFFSET(OFS), .RESET_PERIOD(RSTP)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_period(cfg_period), .cfg_load(cfg_load),
        .pix_clk(pix_clk), .rd_gate_n(rd_gate_n), .conv_start(conv_start)
    );

    task automatic chk(input string req, input int act_v, input int exp_v);
        n_checks++;
        if (act_v != exp_v) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act_v, exp_v);
        end
    endtask

    function automatic int clampv(input int v);
        return (v < MINP) ? MINP : v;
    endfunction

    // One reference cycle: drive at negedge, check after the edge, update model.
    task automatic step(input logic ld, input int v);
        int slot, ph, flen;
        bit fh, wrap;
        cfg_load = ld;
        cfg_period = PW'(v);
        @(posedge clk);
        @(negedge clk);
        cycles++;
        slot = mq / DIV;
        ph = mq % DIV;
        fh = (ph < DIV/2);
        chk({"R1 pixel clock ", tag}, pix_clk, (slot < GATE) || fh);
        chk({"R2 readout gate ", tag}, rd_gate_n, slot >= GATE);
        chk({"R4 conversion start ", tag}, conv_start,
            (slot >= GATE+OFS) && (slot < GATE+OFS+NPIX) && fh);
        if (prev_pix && !pix_clk) falls++;
        if (!prev_conv && conv_start) crises++;
        prev_pix = pix_clk;
        prev_conv = conv_start;
        flen = (GATE + act) * DIV;
        wrap = (mq == flen - 1);
        if (wrap) begin
            chk({"R3 pixel pulses per frame ", tag}, falls, act);
            chk({"R4 conversions per frame ", tag}, crises, NPIX);
            falls = 0;
            crises = 0;
            mq = 0;
            act = pend;
        end else begin
            mq++;
        end
        if (ld) pend = clampv(v);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 0);
    endtask

    // Advance to the last cycle of the frame, then load on that edge.
    task automatic load_at_boundary(input int v);
        while (mq != (GATE + act) * DIV - 1) step(1'b0, 0);
        step(1'b1, v);
    endtask

    task automatic finish_frames(input int nf);
        for (int f = 0; f < nf; f++) begin
            step(1'b0, 0);
            while (mq != 0) step(1'b0, 0);
        end
    endtask

    initial begin
        // R7: reset values held while reset is low
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R7 reset gate", rd_gate_n, 1);
            chk("R7 reset pixel clock", pix_clk, 0);
            chk("R7 reset conversion", conv_start, 0);
        end
        rst_n = 1'b1;
        tag = "R7 first frames";
        finish_frames(2);

        // R5: mid-frame load applies at the next boundary
        tag = "R5 midframe load";
        run(10);
        step(1'b1, 21);
        finish_frames(3);

        // R5: load on the last cycle of a frame skips one frame
        tag = "R5 boundary load";
        load_at_boundary(17);
        finish_frames(2);

        // R6: sweep of values around the minimum
        for (int v = 0; v <= MINP + 2; v++) begin
            tag = $sformatf("R6 value %0d", v);
            run(5);
            step(1'b1, v);
            finish_frames(2);
        end
        tag = "R6 large value";
        step(1'b1, 40);
        finish_frames(2);

        // R7: reset mid-frame restarts cleanly
        tag = "R7 re-reset";
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R7 reset gate again", rd_gate_n, 1);
        chk("R7 reset pixel clock again", pix_clk, 0);
        mq = 0; act = RSTP; pend = RSTP; falls = 0; crises = 0;
        prev_pix = 1'b0; prev_conv = 1'b0;
        rst_n = 1'b1;
        finish_frames(2);
        done = 1;
    end

    initial begin
        while (!done && cycles < 100000) @(negedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule